// File: doc/BRIEF.md
# Programmable Serial Clock Divider

This block derives the serial clock of an SPI host from an 80 MHz source clock. One 32-bit configuration word sets it up. The word carries a pass-through flag and three 6-bit counts: the last count of the period, the last count of the high phase and the last count of the low phase. A free-running phase counter runs from zero up to the period count and then wraps. The serial clock level is derived from where the counter stands against the two phase counts. When the pass-through flag is set, the source clock itself is forwarded, gated by the enable.

Along with the clock, the block drives two one-cycle strobes. They mark the first source cycle of each high phase and of each low phase, so a serial engine in the same clock domain can shift and sample without looking for edges on the divided clock. A new configuration word is adopted only while the divider is stopped or at the end of a full period. Rewriting the word mid-period therefore never shortens a phase.

A separate combinational helper maps an integer divide factor D (1 to 64) onto the configuration word. The resulting serial clock has a period of D source cycles, with D/2 (rounded down) of them high.

Top module: `spi_sclk_gen`

## Requirements
- R1: After reset, and for as long as the divider is stopped, `sclk`, `rise_stb` and `fall_stb` are low.
- R2: Configuration word fields are decoded as follows. Bit 31 is pass-through. Bits [5:0] are the period count N. Bits [11:6] are the high count H. Bits [17:12] are the low count L. All other bits are ignored.
- R3: In divided mode the phase counter runs 0..N and then wraps to 0. `sclk` is high at counts 0..H, low at counts H+1..L, and high again at any count above L. The first count 0 appears in the cycle after `en` is first sampled high.
- R4: `rise_stb` is high exactly in the first cycle of each high phase of `sclk`. `fall_stb` is high exactly in the first cycle of each low phase, including the low phase caused by a stop. Neither strobe is high in any other cycle of divided mode.
- R5: A configuration word is adopted when the divider starts, and otherwise only at the edge where the counter wraps. A word changed mid-period leaves the current period unchanged, whether the change is to a divided setting or to pass-through.
- R6: In pass-through mode `sclk` equals the source clock ANDed with `en`. Both strobes are high in every running cycle.
- R7: When `en` is sampled low, the divider stops in the next cycle: `sclk` goes low and the phase counter is reset. The next start begins again at count 0.
- R8: The helper encodes D=1 (and D=0) as only bit 31 set. For D from 2 to 64 it encodes N=D-1, H=floor(D/2)-1 and L=D-1. Factors above 64 are encoded as 64.
- R9: Driven with a helper word for factor D, the divided clock has a period of D source cycles and a high time of floor(D/2) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 80 MHz source clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low stops the divider |
| cfg_word | input | 32 | Divider configuration word |
| sclk | output | 1 | Serial clock |
| rise_stb | output | 1 | One-cycle strobe at the start of each high phase |
| fall_stb | output | 1 | One-cycle strobe at the start of each low phase |

## Verification
The bench builds the block with its default 6-bit counts and a 7-bit factor input. This brings the full divide range from 1 up to 64 within reach, so the largest period exercises every counter bit before the wrap. It also brings factors beyond 64 within reach, so the helper's clamping is covered. A hand-made word with the low count below the period count covers the second high stretch.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

    localparam int CFG_W   = 32;
    localparam int CNT_W   = 6;
    localparam int FACT_W  = CNT_W + 1;
    localparam int BYP_POS = 31;
    localparam int PER_LSB = 0;
    localparam int HI_LSB  = PER_LSB + CNT_W;
    localparam int LO_LSB  = HI_LSB + CNT_W;
    localparam int MAX_DIV = 1 << CNT_W;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic byp;
        cnt_t lo;
        cnt_t hi;
        cnt_t per;
    } sclk_cfg_t;

    typedef struct packed {
        logic run;
        cnt_t cnt;
        logic lvl;
        logic rise;
        logic fall;
    } phase_t;

    function automatic sclk_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
        sclk_cfg_t c;
        c.byp = w[BYP_POS];
        c.per = w[PER_LSB +: CNT_W];
        c.hi  = w[HI_LSB +: CNT_W];
        c.lo  = w[LO_LSB +: CNT_W];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_from_factor(input logic [FACT_W-1:0] d);
        logic [CFG_W-1:0] w;
        int unsigned      dd;
        w  = '0;
        dd = 32'(d);
        if (dd <= 1) begin
            w[BYP_POS] = 1'b1;
        end else begin
            if (dd > MAX_DIV) dd = MAX_DIV;
            w[PER_LSB +: CNT_W] = CNT_W'(dd - 1);
            w[HI_LSB +: CNT_W]  = CNT_W'(dd / 2 - 1);
            w[LO_LSB +: CNT_W]  = CNT_W'(dd - 1);
        end
        return w;
    endfunction

endpackage

// File: rtl/sclk_cfg_reg.sv
module sclk_cfg_reg
    import sclk_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CFG_W-1:0] cfg_word,
    output sclk_cfg_t        act
);

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= '0;
        end else if (load) begin
            act <= cfg_unpack(cfg_word);
        end
    end

endmodule

// File: rtl/sclk_phase_ctr.sv
module sclk_phase_ctr
    import sclk_div_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  sclk_cfg_t act,
    output logic      load,
    output phase_t    ph
);

    phase_t st_d;
    logic   wrap;
    cnt_t   cnt_nx;
    logic   lvl_nx;

    assign wrap   = act.byp || (ph.cnt == act.per);
    assign cnt_nx = wrap ? '0 : ph.cnt + cnt_t'(1);
    assign lvl_nx = (cnt_nx <= act.hi) || (cnt_nx > act.lo);
    assign load   = !ph.run || !en || wrap;

    always_comb begin
        st_d      = ph;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (!ph.run) begin
            st_d.cnt = '0;
            if (en) begin
                st_d.run  = 1'b1;
                st_d.lvl  = 1'b1;
                st_d.rise = 1'b1;
            end else begin
                st_d.lvl = 1'b0;
            end
        end else if (!en) begin
            st_d.run  = 1'b0;
            st_d.cnt  = '0;
            st_d.lvl  = 1'b0;
            st_d.fall = ph.lvl;
        end else if (act.byp) begin
            st_d.cnt  = '0;
            st_d.lvl  = 1'b1;
            st_d.rise = 1'b1;
        end else begin
            st_d.cnt  = cnt_nx;
            st_d.lvl  = lvl_nx;
            st_d.rise = lvl_nx & ~ph.lvl;
            st_d.fall = ~lvl_nx & ph.lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= '0;
        end else begin
            ph <= st_d;
        end
    end

endmodule

// File: rtl/sclk_out_sel.sv
module sclk_out_sel
    import sclk_div_pkg::*;
(
    input  logic      clk,
    input  logic      en,
    input  sclk_cfg_t act,
    input  phase_t    ph,
    output logic      sclk,
    output logic      rise_stb,
    output logic      fall_stb
);

    always_comb begin
        if (act.byp) begin
            sclk     = clk & en & ph.run;
            rise_stb = ph.run;
            fall_stb = ph.run;
        end else begin
            sclk     = ph.lvl;
            rise_stb = ph.rise;
            fall_stb = ph.fall;
        end
    end

endmodule

// File: rtl/spi_sclk_factor_enc.sv
module spi_sclk_factor_enc
    import sclk_div_pkg::*;
(
    input  logic [FACT_W-1:0] factor,
    output logic [CFG_W-1:0]  cfg_word
);

    assign cfg_word = cfg_from_factor(factor);

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
    import sclk_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             sclk,
    output logic             rise_stb,
    output logic             fall_stb
);

    sclk_cfg_t act_cfg;
    phase_t    ph;
    logic      load;

    sclk_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .cfg_word (cfg_word),
        .act      (act_cfg)
    );

    sclk_phase_ctr u_ctr (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .act  (act_cfg),
        .load (load),
        .ph   (ph)
    );

    sclk_out_sel u_out (
        .clk      (clk),
        .en       (en),
        .act      (act_cfg),
        .ph       (ph),
        .sclk     (sclk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk
    import sclk_div_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      en,
    input logic      sclk,
    input logic      rise_stb,
    input logic      fall_stb,
    input sclk_cfg_t act,
    input phase_t    ph
);

    // R1: stopped divider keeps clock and rise strobe low
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !ph.run |-> (!sclk && !rise_stb));

    // R3: counter never passes the period count in divided mode
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        (ph.run && !act.byp) |-> (ph.cnt <= act.per));

    // R5: active setting holds until the wrap
    p_cfg_held_r5: assert property (@(posedge clk) disable iff (rst)
        (ph.run && en && !act.byp && (ph.cnt != act.per)) |=> $stable(act));

    // R4: rise strobe only on the first high cycle
    p_rise_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (rise_stb && !act.byp) |-> (ph.lvl && (!$past(ph.lvl) || $past(act.byp))));

    // R4: fall strobe only on the first low cycle
    p_fall_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (fall_stb && !act.byp) |-> (!ph.lvl && $past(ph.lvl)));

    // R7: dropping enable stops the divider next cycle
    p_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (ph.run && !en) |=> !ph.run);

endmodule

bind spi_sclk_gen spi_sclk_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .sclk     (sclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .act      (act_cfg),
    .ph       (ph)
);

// File: tb/test_spi_sclk_gen.sv
module test_spi_sclk_gen;

    typedef struct packed {
        logic [6:0]  d;
        logic [31:0] w;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{7'd1,  32'h8000_0000},
        '{7'd2,  32'h0000_1001},
        '{7'd3,  32'h0000_2002},
        '{7'd4,  32'h0000_3043},
        '{7'd5,  32'h0000_4044},
        '{7'd7,  32'h0000_6086},
        '{7'd16, 32'h0000_F1CF},
        '{7'd33, 32'h0002_03E0},
        '{7'd64, 32'h0003_F7FF}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic [31:0] word;
    logic [6:0]  factor;
    logic [31:0] enc_word;
    logic        sclk;
    logic        rise_stb;
    logic        fall_stb;

    int total = 0;
    int bad   = 0;
    bit m_prev;
    bit done  = 0;

    always #2 clk = ~clk;

    spi_sclk_gen i_spi_sclk_gen (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .cfg_word (word),
        .sclk     (sclk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    spi_sclk_factor_enc i_enc (
        .factor   (factor),
        .cfg_word (enc_word)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic start(input logic [31:0] w);
        en   = 1'b0;
        word = w;
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
    endtask

    // compares {sclk,rise,fall} against the phase rule of R3/R4
    task automatic run_seq(input int n, input int start_i, input int N, input int H,
                           input int L, input bit fresh, inout int errs,
                           inout logic [31:0] got, inout logic [31:0] want);
        for (int i = start_i; i < start_i + n; i++) begin
            int c;
            bit el, er, ef;
            c  = i % (N + 1);
            el = (c <= H) || (c > L);
            if (fresh && i == 0) begin
                er = 1'b1;
                ef = 1'b0;
            end else begin
                er = el && !m_prev;
                ef = !el && m_prev;
            end
            m_prev = el;
            @(negedge clk);
            if ({sclk, rise_stb, fall_stb} !== {el, er, ef}) begin
                if (errs == 0) begin
                    got  = {29'b0, sclk, rise_stb, fall_stb};
                    want = {29'b0, el, er, ef};
                end
                errs++;
            end
        end
    endtask

    task automatic bypass_cycles(input int n, inout int errs,
                                 inout logic [31:0] got, inout logic [31:0] want);
        for (int i = 0; i < n; i++) begin
            logic hi_s;
            @(posedge clk);
            #1;
            hi_s = sclk;
            @(negedge clk);
            if ({hi_s, sclk, rise_stb, fall_stb} !== 4'b1011) begin
                if (errs == 0) begin
                    got  = {28'b0, hi_s, sclk, rise_stb, fall_stb};
                    want = 32'hB;
                end
                errs++;
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int          errs;
        logic [31:0] got, want;
        rst    = 1'b1;
        en     = 1'b0;
        word   = 32'h0;
        factor = 7'd1;
        repeat (3) @(negedge clk);
        check({sclk, rise_stb, fall_stb} === 3'b000, "R1", "in reset",
              {29'b0, sclk, rise_stb, fall_stb}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check({sclk, rise_stb, fall_stb} === 3'b000, "R1", "after reset",
              {29'b0, sclk, rise_stb, fall_stb}, 32'h0);

        // table walk: helper encoding (R8) then waveform (R9 / R6)
        for (int k = 0; k < NVEC; k++) begin
            int d;
            d      = int'(VECS[k].d);
            factor = VECS[k].d;
            #1;
            check(enc_word === VECS[k].w, "R8", $sformatf("encode D=%0d", d),
                  enc_word, VECS[k].w);
            errs = 0; got = 0; want = 0;
            start(VECS[k].w);
            if (d == 1) begin
                bypass_cycles(4, errs, got, want);
                check(errs == 0, "R6", "pass-through waveform", got, want);
            end else begin
                run_seq(3 * d, 0, d - 1, d / 2 - 1, d - 1, 1'b1, errs, got, want);
                check(errs == 0, "R9", $sformatf("period/high D=%0d", d), got, want);
            end
        end

        // R8: out-of-range factors
        factor = 7'd0;
        #1;
        check(enc_word === 32'h8000_0000, "R8", "factor 0", enc_word, 32'h8000_0000);
        factor = 7'd100;
        #1;
        check(enc_word === 32'h0003_F7FF, "R8", "factor clamp", enc_word, 32'h0003_F7FF);

        // R2/R3: N=9 H=2 L=6 with unused bits 20 and 25 set
        errs = 0; got = 0; want = 0;
        start(32'h0210_6089);
        run_seq(30, 0, 9, 2, 6, 1'b1, errs, got, want);
        check(errs == 0, "R3", "second high stretch above L (R2 ignored bits)", got, want);

        // R5: divided reload mid-period
        errs = 0; got = 0; want = 0;
        start(32'h0000_70C7);
        run_seq(3, 0, 7, 3, 7, 1'b1, errs, got, want);
        word = 32'h0000_1001;
        run_seq(5, 3, 7, 3, 7, 1'b0, errs, got, want);
        run_seq(6, 0, 1, 0, 1, 1'b0, errs, got, want);
        check(errs == 0, "R5", "reload at wrap only", got, want);

        // R5: divided to pass-through mid-period
        errs = 0; got = 0; want = 0;
        start(32'h0000_70C7);
        run_seq(3, 0, 7, 3, 7, 1'b1, errs, got, want);
        word = 32'h8000_0000;
        run_seq(5, 3, 7, 3, 7, 1'b0, errs, got, want);
        bypass_cycles(3, errs, got, want);
        check(errs == 0, "R5", "switch to pass-through at wrap", got, want);

        // R5: pass-through to divided
        errs = 0; got = 0; want = 0;
        start(32'h8000_0000);
        bypass_cycles(2, errs, got, want);
        word = 32'h0000_3043;
        run_seq(8, 0, 3, 1, 3, 1'b1, errs, got, want);
        check(errs == 0, "R5", "pass-through to divided", got, want);

        // R7: stop during high phase
        errs = 0; got = 0; want = 0;
        start(32'h0000_3043);
        run_seq(2, 0, 3, 1, 3, 1'b1, errs, got, want);
        en = 1'b0;
        @(negedge clk);
        check({sclk, rise_stb, fall_stb} === 3'b001, "R7", "stop cycle",
              {29'b0, sclk, rise_stb, fall_stb}, 32'h1);
        errs = 0;
        word = 32'h0000_1001;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if ({sclk, rise_stb, fall_stb} !== 3'b000) errs++;
        end
        check(errs == 0, "R1", "quiet while stopped", 32'(errs), 32'h0);

        // R7: restart begins at count 0
        errs = 0; got = 0; want = 0;
        en = 1'b1;
        run_seq(6, 0, 1, 0, 1, 1'b1, errs, got, want);
        check(errs == 0, "R7", "restart from count 0", got, want);

        // R6: enable gates the pass-through clock
        errs = 0; got = 0; want = 0;
        start(32'h8000_0000);
        bypass_cycles(2, errs, got, want);
        en = 1'b0;
        @(posedge clk);
        #1;
        check(sclk === 1'b0, "R6", "gated by enable", {31'b0, sclk}, 32'h0);
        @(negedge clk);
        check({rise_stb, fall_stb} === 2'b00, "R6", "strobes after stop",
              {30'b0, rise_stb, fall_stb}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule